// File: doc/BRIEF.md
# Table-Driven Finite State Machine

This block is a fully encoded finite state machine whose transition and output functions are held in a small synchronous RAM instead of gates. On each clock edge where the machine is running, the current input bits and the current state code together form the RAM address. The word read at that edge becomes the new state and the new outputs. A different RAM image gives a different machine, so one block can serve as a sequence detector, a counter or any controller that fits in the table.

Software or a loader fills the table through a write port while the machine is stopped. The machine is then released with the run input. A synchronous reset returns the machine to state code 0 with all outputs low, whatever the table holds, and it leaves the table contents in place.

Top module: `ucfsm_engine`

## Requirements
- R1: The lookup address is the input bits above the state bits, so entry index = in_bits * 2^STATE_W + state (with defaults, index = in_bits*4 + state_o).
- R2: A table word carries the next state code in its low STATE_W bits and the outputs above them (with defaults, bits [1:0] next state and bits [5:2] outputs).
- R3: On a rising edge with run high and rst low, state_o and out_o both take the fields of the entry addressed by the in_bits and state_o present before that edge, so outputs always belong to the state being entered.
- R4: The state is fully encoded in STATE_W bits; every code from 0 to 2^STATE_W-1 is a legal state, and reloading the table changes the machine's behaviour entirely.
- R5: A rising edge with rst high sets state_o to 0 and out_o to 0, whether run is high or low and whatever the table holds.
- R6: With run low and rst low, state_o and out_o keep their values across edges, whatever in_bits does.
- R7: A write requested while run is high is dropped; the addressed entry keeps its old word.
- R8: A write with run low stores wdata at waddr on that edge; a later write to the same address replaces it.
- R9: Reset does not alter the table; entries written before a reset still steer the machine after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of state and outputs |
| run | input | 1 | High: step the machine each edge and block table writes |
| in_bits | input | IN_W (2) | Machine inputs, upper part of the lookup address |
| we | input | 1 | Table write request |
| waddr | input | IN_W+STATE_W (4) | Table entry to write |
| wdata | input | OUT_W+STATE_W (6) | Word to write, outputs above next state |
| state_o | output | STATE_W (2) | Current state code |
| out_o | output | OUT_W (4) | Registered machine outputs |

## Verification
A wrong state code shows at state_o on the very edge it is entered, and because the next address is built from it, every following step reads a different entry, so out_o diverges from the reference model within one more edge. A misplaced address field or swapped word field shows on the first step whose input differs from zero. A write that slips through while running, or a reset that disturbs the table, is exposed by stepping the machine through the affected entry and comparing both outputs against the expected word.

// File: rtl/ucfsm_pkg.sv
package ucfsm_pkg;
  // Default geometry of the table-driven state machine.
  localparam int unsigned DEF_STATE_W = 2;
  localparam int unsigned DEF_IN_W    = 2;
  localparam int unsigned DEF_OUT_W   = 4;

  // Code the machine returns to on reset.
  localparam int unsigned START_CODE  = 0;
endpackage

// File: rtl/ucfsm_addr.sv
module ucfsm_addr #(
  parameter int unsigned STATE_W = 2,
  parameter int unsigned IN_W    = 2,
  localparam int unsigned AW     = STATE_W + IN_W
) (
  input  logic [IN_W-1:0]    in_bits,
  input  logic [STATE_W-1:0] state,
  output logic [AW-1:0]      addr
);
  // R1: inputs form the high part of the address, state the low part.
  always_comb begin
    addr = {in_bits, state};
  end
endmodule

// File: rtl/ucfsm_table.sv
module ucfsm_table #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 6,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          en,
  input  logic          lock,
  input  logic [AW-1:0] raddr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  // Write side: accepted only while the machine is stopped (R7, R8).
  always_ff @(posedge clk) begin
    if (we && !lock) begin
      mem[waddr] <= wdata;
    end
  end

  // Read side: output register with synchronous reset and clock enable.
  // This register is the state register of the machine (R3, R5, R6).
  always_ff @(posedge clk) begin
    if (srst) begin
      rq <= '0;
    end else if (en) begin
      rq <= mem[raddr];
    end
  end

  a_r5_reset_clears: assert property (@(posedge clk)
    srst |=> rq == '0);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (srst)
    !en |=> $stable(rq));

  a_r3_lookup_word: assert property (@(posedge clk) disable iff (srst)
    en && !we |=> rq == $past(mem[raddr]));

  a_r7_locked_write: assert property (@(posedge clk)
    we && lock |=> mem[$past(waddr)] == $past(mem[waddr]));

  a_r8_write_lands: assert property (@(posedge clk)
    we && !lock |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/ucfsm_split.sv
module ucfsm_split #(
  parameter int unsigned STATE_W = 2,
  parameter int unsigned OUT_W   = 4,
  localparam int unsigned DW     = STATE_W + OUT_W
) (
  input  logic [DW-1:0]      word,
  output logic [STATE_W-1:0] state,
  output logic [OUT_W-1:0]   outs
);
  // R2: next-state field in the low bits, outputs above it.
  always_comb begin
    state = word[STATE_W-1:0];
    outs  = word[DW-1:STATE_W];
  end
endmodule

// File: rtl/ucfsm_engine.sv
module ucfsm_engine
  import ucfsm_pkg::*;
#(
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned IN_W    = DEF_IN_W,
  parameter int unsigned OUT_W   = DEF_OUT_W,
  localparam int unsigned AW     = STATE_W + IN_W,
  localparam int unsigned DW     = STATE_W + OUT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [IN_W-1:0]    in_bits,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [STATE_W-1:0] state_o,
  output logic [OUT_W-1:0]   out_o
);
  logic [AW-1:0]      look_addr;
  logic [DW-1:0]      cur_word;
  logic [STATE_W-1:0] cur_state;
  logic [OUT_W-1:0]   cur_outs;

  ucfsm_addr #(.STATE_W(STATE_W), .IN_W(IN_W)) u_addr (
    .in_bits (in_bits),
    .state   (cur_state),
    .addr    (look_addr)
  );

  ucfsm_table #(.AW(AW), .DW(DW)) u_table (
    .clk   (clk),
    .srst  (rst),
    .en    (run),
    .lock  (run),
    .raddr (look_addr),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .rq    (cur_word)
  );

  ucfsm_split #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_split (
    .word  (cur_word),
    .state (cur_state),
    .outs  (cur_outs)
  );

  assign state_o = cur_state;
  assign out_o   = cur_outs;

  a_r5_start_state: assert property (@(posedge clk)
    rst |=> state_o == STATE_W'(START_CODE) && out_o == '0);

  a_r6_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(state_o) && $stable(out_o));
endmodule

// File: tb/test_ucfsm_engine.sv
module test_ucfsm_engine;
  logic       clk = 1'b0;
  logic       rst, run, we;
  logic [1:0] in_bits;
  logic [3:0] waddr;
  logic [5:0] wdata;
  logic [1:0] state_o;
  logic [3:0] out_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ucfsm_engine i_ucfsm_engine (
    .clk(clk), .rst(rst), .run(run), .in_bits(in_bits),
    .we(we), .waddr(waddr), .wdata(wdata),
    .state_o(state_o), .out_o(out_o)
  );

  // Input stream: bit0 serial data, bit1 clears the detector.
  localparam logic [1:0] STIM [0:19] = '{
    2'd1, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1,
    2'd0, 2'd1, 2'd3, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0};

  // Reference: detector for pattern 1,0,1 with overlap.
  function automatic logic [1:0] det_next(logic [1:0] s, logic [1:0] i);
    if (i[1]) return 2'd0;
    case (s)
      2'd0: return i[0] ? 2'd1 : 2'd0;
      2'd1: return i[0] ? 2'd1 : 2'd2;
      2'd2: return i[0] ? 2'd3 : 2'd0;
      default: return i[0] ? 2'd1 : 2'd2;
    endcase
  endfunction

  function automatic logic [3:0] det_out(logic [1:0] ns);
    return 4'b0001 << ns;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic write_word(logic [3:0] a, logic [5:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(logic [1:0] i);
    in_bits = i;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] ms;
    logic [1:0] hs;
    logic [3:0] ho;
    rst = 1'b1; run = 1'b0; we = 1'b0; in_bits = '0; waddr = '0; wdata = '0;
    repeat (2) @(negedge clk);

    // R1, R2: entry {in,state} holds {outputs, next}.
    for (int a = 0; a < 16; a++) begin
      logic [1:0] ns;
      ns = det_next(a[1:0], a[3:2]);
      write_word(a[3:0], {det_out(ns), ns});
    end
    rst = 1'b0;
    @(negedge clk);
    check("R5 reset state", state_o, 0);
    check("R5 reset outputs", out_o, 0);

    // R1 R2 R3: walk the stimulus table against the reference model.
    run = 1'b1;
    ms = 2'd0;
    for (int k = 0; k < 20; k++) begin
      step(STIM[k]);
      ms = det_next(ms, STIM[k]);
      check("R3 R1 state", state_o, ms);
      check("R3 R2 outputs", out_o, det_out(ms));
    end

    // R6: stopped machine ignores inputs.
    run = 1'b0;
    hs = state_o; ho = out_o;
    step(2'd1); step(2'd0); step(2'd1);
    check("R6 hold state", state_o, hs);
    check("R6 hold outputs", out_o, ho);

    // R7: write during run is dropped.
    do_reset();
    run = 1'b1; in_bits = 2'd2;
    we = 1'b1; waddr = 4'd0; wdata = 6'h3F;
    @(negedge clk);
    we = 1'b0;
    check("R7 state after blocked write", state_o, 0);
    step(2'd0);
    check("R7 entry kept state", state_o, 0);
    check("R7 entry kept outputs", out_o, 4'b0001);

    // R8: write while stopped, last write wins.
    run = 1'b0;
    write_word(4'd0, 6'h15);
    write_word(4'd0, {4'b1010, 2'b11});
    run = 1'b1;
    step(2'd0);
    check("R8 new state", state_o, 3);
    check("R8 new outputs", out_o, 4'b1010);

    // R5 with run high, then R9 table survives reset.
    rst = 1'b1; in_bits = 2'd1;
    @(negedge clk);
    check("R5 reset while running state", state_o, 0);
    check("R5 reset while running outputs", out_o, 0);
    rst = 1'b0;
    step(2'd0);
    check("R9 entry after reset state", state_o, 3);
    check("R9 entry after reset outputs", out_o, 4'b1010);

    // R4: reload as a counter, outputs {in, next}; visits all codes and wraps.
    run = 1'b0;
    for (int a = 0; a < 16; a++) begin
      logic [1:0] ns;
      ns = a[1:0] + 2'd1;
      write_word(a[3:0], {a[3:2], ns, ns});
    end
    do_reset();
    run = 1'b1;
    ms = 2'd0;
    for (int k = 0; k < 6; k++) begin
      logic [1:0] iv;
      iv = 2'(k);
      step(iv);
      ms = ms + 2'd1;
      check("R4 counter state", state_o, ms);
      check("R4 counter outputs", out_o, {iv, ms});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule